// File: doc/BRIEF.md
# Toggle-Request Half-Cycle RAM

This block is a single-port word memory that sits beside a datapath clocked on the rising edge. The datapath asks for an access by inverting a one-bit request flag, and it latches the address, the direction and the store data on the same rising edge. The memory array works on the falling edge. On that edge it compares its own acknowledge flag with the request flag. If the two differ, it performs the access and copies the request flag, so the access runs exactly once. A load therefore fills the read register half a cycle after it is issued. The datapath copies that value into a destination register on the next rising edge, so a load costs one cycle and needs no wait states.

The user drives a request strobe for each cycle in which an access is wanted, together with the direction, address and store data. Requests may arrive on every cycle. The array depth does not need to be a power of two. An address at or beyond the depth is treated as unmapped: a store to it is dropped and a load from it returns zero. The reset input is asynchronous and active low. Its release is synchronised to the rising edge inside the block, and reset clears the request flag and the acknowledge flag to the same value.

Top module: `tog_ram`

## Requirements
- R1: While reset is held, and after it is released, with no access yet made, `rd_data_o` and `dst_o` read zero and `dst_vld_o` is low.
- R2: A load sampled on rising edge k drives `dst_vld_o` high for the single cycle after rising edge k+1, with `dst_o` holding the loaded word. `dst_vld_o` is low in every other cycle.
- R3: A store sampled on rising edge k is written into the array before rising edge k+1, so a load from the same address sampled on edge k+1 returns the new word.
- R4: `rd_data_o` shows the result of a load from the falling edge that follows the rising edge which sampled the load.
- R5: In a cycle with no request, `rd_data_o`, `dst_o` and the array contents keep their values, and `dst_vld_o` is low.
- R6: A store (`wr_i` = 1) leaves `rd_data_o` and `dst_o` unchanged.
- R7: A store to an address greater than or equal to DEPTH changes no word of the array.
- R8: A load (`wr_i` = 0) from an address greater than or equal to DEPTH returns zero.
- R9: Requests on consecutive cycles are each serviced exactly once and in order. At every rising edge after reset, the acknowledge flag equals the request flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. The datapath acts on the rising edge and the array on the falling edge. |
| rst_n | input | 1 | Asynchronous active-low reset with synchronous release. |
| req_i | input | 1 | Access request for this cycle. |
| wr_i | input | 1 | Access direction: 1 is a store, 0 is a load. |
| addr_i | input | AW | Word address. |
| wdata_i | input | DW | Store data. |
| rd_data_o | output | DW | Array read register, updated on the falling edge. |
| dst_o | output | DW | Destination register, filled on the rising edge after a load. |
| dst_vld_o | output | 1 | High for the cycle in which `dst_o` holds a freshly loaded word. |

## Verification
The array is first filled with stores on back-to-back cycles. It is then read back with loads on back-to-back cycles. This separates a design that services each toggle exactly once from one that merges or repeats requests. Pairs of a store and a load to the same address on adjacent cycles show whether a store truly completes within its own cycle. Idle gaps, stores that follow loads, and out-of-range addresses in both directions show whether a stale read register or a spurious write leaks through. A long mixed run with pseudo-random addresses then checks every read and destination value against a behavioural memory model.

// File: rtl/tog_ram_pkg.sv
package tog_ram_pkg;

  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } op_e;

  localparam int RST_SYNC_STAGES = 2;

endpackage

// File: rtl/tog_rst_sync.sv
module tog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/tog_ram_issue.sv
module tog_ram_issue
  import tog_ram_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  op_e           op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          flag_o,
  output op_e           op_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          ld_pend_o,
  output logic [DW-1:0] dst_o,
  output logic          dst_vld_o
);

  logic          flag_q,    flag_d;
  op_e           op_q,      op_d;
  logic [AW-1:0] addr_q,    addr_d;
  logic [DW-1:0] wdata_q,   wdata_d;
  logic          ld_pend_q, ld_pend_d;
  logic [DW-1:0] dst_q,     dst_d;
  logic          vld_q,     vld_d;

  always_comb begin
    flag_d    = flag_q;
    op_d      = op_q;
    addr_d    = addr_q;
    wdata_d   = wdata_q;
    dst_d     = dst_q;
    ld_pend_d = req_i && (op_i == OP_LOAD);
    vld_d     = ld_pend_q;
    if (req_i) begin
      flag_d  = ~flag_q;
      op_d    = op_i;
      addr_d  = addr_i;
      wdata_d = wdata_i;
    end
    if (ld_pend_q) begin
      dst_d = rd_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q    <= 1'b0;
      op_q      <= OP_LOAD;
      addr_q    <= '0;
      wdata_q   <= '0;
      ld_pend_q <= 1'b0;
      dst_q     <= '0;
      vld_q     <= 1'b0;
    end else begin
      flag_q    <= flag_d;
      op_q      <= op_d;
      addr_q    <= addr_d;
      wdata_q   <= wdata_d;
      ld_pend_q <= ld_pend_d;
      dst_q     <= dst_d;
      vld_q     <= vld_d;
    end
  end

  assign flag_o    = flag_q;
  assign op_o      = op_q;
  assign addr_o    = addr_q;
  assign wdata_o   = wdata_q;
  assign ld_pend_o = ld_pend_q;
  assign dst_o     = dst_q;
  assign dst_vld_o = vld_q;

endmodule

// File: rtl/tog_ram_array.sv
module tog_ram_array
  import tog_ram_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 12,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flag_i,
  input  op_e           op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o
);

  localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic          ack_q, ack_d;
  logic [DW-1:0] rd_q,  rd_d;
  logic          active, hit, wr_en;

  always_comb begin
    active = (flag_i != ack_q);
    hit    = ({1'b0, addr_i} < LIMIT);
    wr_en  = active && (op_i == OP_STORE) && hit;
    ack_d  = active ? flag_i : ack_q;
    rd_d   = rd_q;
    if (active && (op_i == OP_LOAD)) begin
      rd_d = hit ? mem_q[addr_i] : '0;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      ack_q <= ack_d;
      rd_q  <= rd_d;
    end
  end

  always_ff @(negedge clk) begin
    if (wr_en) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign ack_o   = ack_q;
  assign rdata_o = rd_q;

endmodule

// File: rtl/tog_ram.sv
module tog_ram
  import tog_ram_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 12,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rd_data_o,
  output logic [DW-1:0] dst_o,
  output logic          dst_vld_o
);

  logic          rst_sync_n;
  logic          dp_flag;
  logic          ram_flag;
  op_e           acc_op;
  logic [AW-1:0] acc_addr;
  logic [DW-1:0] acc_wdata;
  logic          ld_pend;
  logic [DW-1:0] rd_q;

  tog_rst_sync #(
    .STAGES(RST_SYNC_STAGES)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  tog_ram_issue #(
    .DW(DW),
    .AW(AW)
  ) u_issue (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .req_i    (req_i),
    .op_i     (op_e'(wr_i)),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rd_data_i(rd_q),
    .flag_o   (dp_flag),
    .op_o     (acc_op),
    .addr_o   (acc_addr),
    .wdata_o  (acc_wdata),
    .ld_pend_o(ld_pend),
    .dst_o    (dst_o),
    .dst_vld_o(dst_vld_o)
  );

  tog_ram_array #(
    .DW   (DW),
    .DEPTH(DEPTH),
    .AW   (AW)
  ) u_array (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .flag_i (dp_flag),
    .op_i   (acc_op),
    .addr_i (acc_addr),
    .wdata_i(acc_wdata),
    .ack_o  (ram_flag),
    .rdata_o(rd_q)
  );

  assign rd_data_o = rd_q;

endmodule

// File: rtl/tog_ram_chk.sv
module tog_ram_chk
  import tog_ram_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 12,
  parameter int AW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dp_flag,
  input logic          ram_flag,
  input op_e           acc_op,
  input logic [AW-1:0] acc_addr,
  input logic          ld_pend,
  input logic [DW-1:0] rd_q,
  input logic [DW-1:0] dst_q,
  input logic          dst_vld
);

  localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

  assert_flags_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_flag == dp_flag);

  assert_dst_vld_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_pend |=> dst_vld);

  assert_dst_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dst_vld |-> (dst_q == $past(rd_q)));

  assert_idle_hold_R5: assert property (@(negedge clk) disable iff (!rst_n)
    (ram_flag == dp_flag) |=> $stable(rd_q));

  assert_store_rd_R6: assert property (@(negedge clk) disable iff (!rst_n)
    ((ram_flag != dp_flag) && (acc_op == OP_STORE)) |=> $stable(rd_q));

  assert_oob_zero_R8: assert property (@(negedge clk) disable iff (!rst_n)
    ((ram_flag != dp_flag) && (acc_op == OP_LOAD) && ({1'b0, acc_addr} >= LIMIT))
      |=> (rd_q == '0));

endmodule

bind tog_ram tog_ram_chk #(
  .DW   (DW),
  .DEPTH(DEPTH),
  .AW   (AW)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .dp_flag (dp_flag),
  .ram_flag(ram_flag),
  .acc_op  (acc_op),
  .acc_addr(acc_addr),
  .ld_pend (ld_pend),
  .rd_q    (rd_q),
  .dst_q   (dst_o),
  .dst_vld (dst_vld_o)
);

// File: tb/tog_ram_tb.sv
module tog_ram_tb;

  localparam int PERIOD = 10;
  localparam int DW     = 32;
  localparam int DEPTH  = 12;
  localparam int AW     = $clog2(DEPTH);

  logic          clk;
  logic          rst_n;
  logic          req_i;
  logic          wr_i;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] wdata_i;
  logic [DW-1:0] rd_data_o;
  logic [DW-1:0] dst_o;
  logic          dst_vld_o;

  int n_checks = 0;
  int n_fail   = 0;

  logic [DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0] exp_rd;
  logic [DW-1:0] exp_dst;
  logic          pend_load;
  int unsigned   lfsr;

  tog_ram #(
    .DW   (DW),
    .DEPTH(DEPTH)
  ) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req_i),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rd_data_o(rd_data_o),
    .dst_o    (dst_o),
    .dst_vld_o(dst_vld_o)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One datapath cycle: drive inputs, check the destination side after the
  // rising edge, then update the model and check the read register after
  // the falling edge.
  task automatic step(input logic req, input logic wr, input int a,
                      input logic [DW-1:0] d, input string tag);
    req_i   = req;
    wr_i    = wr;
    addr_i  = AW'(a);
    wdata_i = d;
    @(posedge clk);
    #1;
    if (pend_load) exp_dst = exp_rd;
    chk("R2 dst_vld", {31'b0, dst_vld_o}, {31'b0, pend_load});
    chk("R2 dst", dst_o, exp_dst);
    @(negedge clk);
    #1;
    if (req) begin
      if (wr) begin
        if (a < DEPTH) ref_mem[a] = d;
      end else begin
        exp_rd = (a < DEPTH) ? ref_mem[a] : '0;
      end
    end
    chk(tag, rd_data_o, exp_rd);
    pend_load = req && !wr;
  endtask

  initial begin
    #(PERIOD * 20000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    req_i = 1'b0; wr_i = 1'b0; addr_i = '0; wdata_i = '0;
    exp_rd = '0; exp_dst = '0; pend_load = 1'b0; lfsr = 32'hACE1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rd reset", rd_data_o, '0);
    chk("R1 dst reset", dst_o, '0);
    chk("R1 vld reset", {31'b0, dst_vld_o}, '0);
    @(negedge clk);
    #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R1 rd after release", rd_data_o, '0);
    chk("R1 dst after release", dst_o, '0);

    // Fill the whole array with back-to-back stores.
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b1, i, 32'hA500_0000 + 32'(i * 32'h0101_0011), "R9 fill R6");
    // Idle cycles.
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 0, 32'hDEAD_BEEF, "R5 idle");
    // Back-to-back loads of every word.
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, i, '0, "R4 R9 load");
    step(1'b0, 1'b1, 3, 32'h1111_2222, "R5 idle after load");
    step(1'b0, 1'b0, 0, '0, "R5 idle");
    // Store immediately followed by a load of the same word.
    step(1'b1, 1'b1, 5, 32'h5555_AAAA, "R6 store");
    step(1'b1, 1'b0, 5, '0, "R3 load after store");
    step(1'b1, 1'b1, 0, 32'h0F0F_0F0F, "R6 store after load");
    step(1'b1, 1'b0, 0, '0, "R3 load after store");
    // Unmapped addresses.
    step(1'b1, 1'b1, 13, 32'hBAD0_0013, "R7 oob store");
    step(1'b1, 1'b0, 13, '0, "R8 oob load");
    step(1'b1, 1'b0, 2, '0, "R4 load");
    step(1'b1, 1'b0, 15, '0, "R8 oob load");
    step(1'b1, 1'b1, (1 << AW) - 1, 32'hBAD0_00FF, "R7 oob store");
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, i, '0, "R7 readback");
    // Mixed pseudo-random traffic.
    for (int i = 0; i < 300; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 32'h0);
      step(lfsr[0] | lfsr[7], lfsr[1], int'(lfsr[5:2]), {lfsr[15:0], lfsr[31:16] ^ 16'h3C5A}, "R9 mixed");
    end
    step(1'b0, 1'b0, 0, '0, "R5 final idle");
    step(1'b0, 1'b0, 0, '0, "R5 final idle");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule